// File: doc/BRIEF.md
# Event-Capturing General-Purpose I/O Controller

This block controls 32 general-purpose pins through six 32-bit registers on a simple word-wide register bus. Each pin is either an output, which drives the stored data bit, or an input, whose external level is synchronized and written into the data bit by hardware. An open-drain selection is held for each pin and exported so that the pad ring can act on it. The pad drivers themselves are not part of this block.

Transitions on input pins set sticky event bits. A control bit for each pin selects what counts as an event: any change of level, or only a high-to-low transition. Software clears event bits by writing ones to them. A single interrupt line is high whenever an event is pending on a pin whose mask bit is set. Pin numbering runs from the most significant register bit down: pin n lives at register bit 31-n.

Top module: `gpio_evt_ctrl`

## Requirements
- R1: Registers sit at byte offsets 0x00 direction, 0x04 open-drain, 0x08 data, 0x0C event, 0x10 mask and 0x14 control. A full-word read with `bus_sel`=1 and `bus_wr`=0 returns the addressed register on `bus_rdata` in the same cycle.
- R2: An access with `bus_word`=0 reads as zero, and a write of that kind changes no register.
- R3: A read from any other offset returns zero, and a write to any other offset changes no register.
- R4: Pin n maps to register bit 31-n. Port bit n of `pin_in`, `pin_out`, `pin_oe` and `pin_od` is pin n.
- R5: `pin_oe` carries the direction register, where 1 means output. `pin_od` carries the open-drain register. `pin_out` carries the data register.
- R6: For a pin whose direction bit is 0, a level applied on `pin_in` appears in the data register three clock edges later (two synchronizer stages, then the capture).
- R7: A write to the event register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R8: `irq` is 1 exactly when the bitwise AND of the event and mask registers is nonzero.
- R9: For an input pin whose control bit is 0, any change of the synchronized level sets its event bit. With the control bit at 1, only a 1-to-0 change sets it.
- R10: Reset clears all six registers, so every pin starts as an input with no events and interrupts masked.
- R11: Output pins ignore `pin_in`: their data bits change only through software writes, and they raise no events. A data write leaves the bits of input pins to hardware.
- R12: When a new event on a pin and a software clear of that event bit fall on the same clock edge, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = full 32-bit access |
| bus_addr | input | 12 | Byte offset within the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| pin_in | input | 32 | External pin levels, bit n is pin n |
| pin_out | output | 32 | Data value for each pin |
| pin_oe | output | 32 | Output enable (direction) for each pin |
| pin_od | output | 32 | Open-drain selection for each pin |
| irq | output | 1 | Interrupt, high while an unmasked event is pending |

## Verification
The bench aims at the pin ordering, since a design that reversed it would drive and sample the wrong pins and light the wrong event bits. It checks falling-only pins against a rising edge, which a design that ignored the control bit would report as an event. It lands an input edge on the same edge as a clear of that event, and a design that let the clear win would lose the event. It also applies external toggles to output pins, narrow writes and unmapped writes, where a careless decode or capture path would change the stored state.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

  localparam int unsigned REG_W = 32;

  localparam logic [15:0] OFF_DIR = 16'h0000;
  localparam logic [15:0] OFF_ODR = 16'h0004;
  localparam logic [15:0] OFF_DAT = 16'h0008;
  localparam logic [15:0] OFF_EVT = 16'h000C;
  localparam logic [15:0] OFF_MSK = 16'h0010;
  localparam logic [15:0] OFF_CTL = 16'h0014;

  typedef enum logic [2:0] {
    SEL_DIR,
    SEL_ODR,
    SEL_DAT,
    SEL_EVT,
    SEL_MSK,
    SEL_CTL,
    SEL_NONE
  } reg_sel_e;

  // Byte offset to register select; every other offset is unmapped.
  function automatic reg_sel_e decode_off(input logic [15:0] off);
    case (off)
      OFF_DIR: return SEL_DIR;
      OFF_ODR: return SEL_ODR;
      OFF_DAT: return SEL_DAT;
      OFF_EVT: return SEL_EVT;
      OFF_MSK: return SEL_MSK;
      OFF_CTL: return SEL_CTL;
      default: return SEL_NONE;
    endcase
  endfunction

  // One pin: does the move from prev to now count as an event?
  function automatic logic edge_hit(input logic prev, input logic now,
                                    input logic fall_only);
    if (fall_only) return prev & ~now;
    return prev ^ now;
  endfunction

endpackage

// File: rtl/gpio_evt_sync.sv
module gpio_evt_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_d,
  output logic [W-1:0] sync_q
);

  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= async_d;
      for (int s = 1; s < STAGES; s++) begin
        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign sync_q = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
  import gpio_evt_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] dat_q,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] ctl_q,
  output logic [W-1:0] evt_set
);

  // Compare the synchronized level with the level last captured in the
  // data register; only input pins may raise an event.
  for (genvar b = 0; b < W; b++) begin : g_bit
    assign evt_set[b] = ~dir_q[b] & edge_hit(dat_q[b], lvl[b], ctl_q[b]);
  end

endmodule

// File: rtl/gpio_evt_regs.sv
module gpio_evt_regs
  import gpio_evt_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic          bus_word,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  in_lvl,
  input  logic [W-1:0]  evt_set,
  output logic [W-1:0]  dir_q,
  output logic [W-1:0]  odr_q,
  output logic [W-1:0]  dat_q,
  output logic [W-1:0]  evt_q,
  output logic [W-1:0]  msk_q,
  output logic [W-1:0]  ctl_q,
  output logic          msk_wr
);

  reg_sel_e   sel;
  logic       wr_ok, rd_ok;
  logic       wr_dir, wr_odr, wr_dat, wr_evt, wr_ctl;
  logic [W-1:0] sw_part, dat_nxt, clr_mask, evt_nxt;

  assign sel    = decode_off(16'(bus_addr));
  assign wr_ok  = bus_sel & bus_wr & bus_word;
  assign rd_ok  = bus_sel & ~bus_wr & bus_word;
  assign wr_dir = wr_ok && (sel == SEL_DIR);
  assign wr_odr = wr_ok && (sel == SEL_ODR);
  assign wr_dat = wr_ok && (sel == SEL_DAT);
  assign wr_evt = wr_ok && (sel == SEL_EVT);
  assign msk_wr = wr_ok && (sel == SEL_MSK);
  assign wr_ctl = wr_ok && (sel == SEL_CTL);

  // Output bits belong to software, input bits to the capture path.
  assign sw_part  = wr_dat ? bus_wdata : dat_q;
  assign dat_nxt  = (sw_part & dir_q) | (in_lvl & ~dir_q);
  // Clear first, then set: a same-edge event survives the clear.
  assign clr_mask = wr_evt ? bus_wdata : '0;
  assign evt_nxt  = (evt_q & ~clr_mask) | evt_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      odr_q <= '0;
      dat_q <= '0;
      evt_q <= '0;
      msk_q <= '0;
      ctl_q <= '0;
    end else begin
      if (wr_dir) dir_q <= bus_wdata;
      if (wr_odr) odr_q <= bus_wdata;
      if (msk_wr) msk_q <= bus_wdata;
      if (wr_ctl) ctl_q <= bus_wdata;
      dat_q <= dat_nxt;
      evt_q <= evt_nxt;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_ok) begin
      case (sel)
        SEL_DIR: bus_rdata = dir_q;
        SEL_ODR: bus_rdata = odr_q;
        SEL_DAT: bus_rdata = dat_q;
        SEL_EVT: bus_rdata = evt_q;
        SEL_MSK: bus_rdata = msk_q;
        SEL_CTL: bus_rdata = ctl_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  // R7: bits written as 1 are gone next cycle unless an edge re-set them
  a_r7_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> ((evt_q & $past(bus_wdata) & ~$past(evt_set)) == '0));

  // R12: a fresh event is always present on the following cycle
  a_r12_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_set) |=> ((evt_q & $past(evt_set)) == $past(evt_set)));

  // R11: without a data write, output-pin data bits hold
  a_r11_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dat |=> (((dat_q ^ $past(dat_q)) & $past(dir_q)) == '0));

  // R2: narrow writes change no software-owned register
  a_r2_narrow_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !bus_word) |=>
      ($stable(dir_q) && $stable(odr_q) && $stable(msk_q) && $stable(ctl_q)));

  // R2: narrow reads return zero
  a_r2_narrow_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_word) |-> (bus_rdata == '0));

  // R3: writes to unmapped offsets change no software-owned register
  a_r3_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && sel == SEL_NONE) |=>
      ($stable(dir_q) && $stable(odr_q) && $stable(msk_q) && $stable(ctl_q)));

endmodule

// File: rtl/gpio_evt_ctrl.sv
module gpio_evt_ctrl
  import gpio_evt_pkg::*;
#(
  parameter int unsigned W           = REG_W,
  parameter int unsigned AW          = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic          bus_word,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe,
  output logic [W-1:0]  pin_od,
  output logic          irq
);

  localparam int unsigned MSB = W - 1;

  logic [W-1:0] in_bits;    // pin_in in register bit order
  logic [W-1:0] sync_lvl;
  logic [W-1:0] evt_set;
  logic [W-1:0] dir_q, odr_q, dat_q, evt_q, msk_q, ctl_q;
  logic         msk_wr;

  // Pin n <-> register bit MSB-n
  for (genvar n = 0; n < W; n++) begin : g_pin
    assign in_bits[n]    = pin_in[MSB-n];
    assign pin_out[n]    = dat_q[MSB-n];
    assign pin_oe[n]     = dir_q[MSB-n];
    assign pin_od[n]     = odr_q[MSB-n];
  end

  gpio_evt_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_d(in_bits),
    .sync_q (sync_lvl)
  );

  gpio_evt_detect #(.W(W)) u_detect (
    .lvl    (sync_lvl),
    .dat_q  (dat_q),
    .dir_q  (dir_q),
    .ctl_q  (ctl_q),
    .evt_set(evt_set)
  );

  gpio_evt_regs #(.W(W), .AW(AW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_word (bus_word),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .in_lvl   (sync_lvl),
    .evt_set  (evt_set),
    .dir_q    (dir_q),
    .odr_q    (odr_q),
    .dat_q    (dat_q),
    .evt_q    (evt_q),
    .msk_q    (msk_q),
    .ctl_q    (ctl_q),
    .msk_wr   (msk_wr)
  );

  assign irq = |(evt_q & msk_q);

  // R8: an event on an unmasked pin raises irq on the next cycle
  a_r8_irq_follow: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(evt_set & msk_q)) && !msk_wr) |=> irq);

  // R6: input-pin data equals the synchronized level one edge earlier
  a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (((dat_q ^ $past(sync_lvl)) & ~$past(dir_q)) == '0));

  // R9: a newly set event on a falling-only input pin needs a 1-to-0 data move
  a_r9_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
    (((evt_q & ~$past(evt_q) & $past(ctl_q) & ~$past(dir_q))
      & ~($past(dat_q) & ~dat_q)) == '0));

endmodule

// File: tb/gpio_evt_ctrl_tb_top.sv
module gpio_evt_ctrl_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_word = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe, pin_od;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  gpio_evt_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .pin_od(pin_od), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_reg [6];          // dir, odr, dat, evt, msk, ctl
  logic [31:0] m_pipe [$];         // synchronizer stages, oldest first

  function automatic logic [31:0] to_bits(input logic [31:0] pins);
    logic [31:0] r;
    for (int n = 0; n < 32; n++) r[31-n] = pins[n];
    return r;
  endfunction

  function automatic int slot_of(input logic [11:0] a);
    if (a[1:0] != 2'b00 || a > 12'h014) return -1;
    return int'(a) / 4;
  endfunction

  function automatic logic [31:0] exp_read();
    int s;
    if (!(bus_sel && !bus_wr && bus_word)) return 32'h0;
    s = slot_of(bus_addr);
    if (s < 0) return 32'h0;
    return m_reg[s];
  endfunction

  initial begin
    for (int i = 0; i < 6; i++) m_reg[i] = '0;
    m_pipe = '{32'h0, 32'h0};
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 6; i++) m_reg[i] <= '0;
      m_pipe <= '{32'h0, 32'h0};
    end else begin
      logic [31:0] lvl, nd, ne;
      int s;
      lvl = m_pipe[0];
      nd  = m_reg[2];
      ne  = m_reg[3];
      s   = (bus_sel && bus_wr && bus_word) ? slot_of(bus_addr) : -1;
      for (int n = 0; n < 32; n++) begin
        int b;
        b = 31 - n;
        if (s == 3 && bus_wdata[b]) ne[b] = 1'b0;
        if (m_reg[0][b]) begin
          if (s == 2) nd[b] = bus_wdata[b];
        end else begin
          if (m_reg[5][b]) begin
            if (m_reg[2][b] == 1'b1 && lvl[b] == 1'b0) ne[b] = 1'b1;
          end else if (m_reg[2][b] != lvl[b]) begin
            ne[b] = 1'b1;
          end
          nd[b] = lvl[b];
        end
      end
      m_reg[2] <= nd;
      m_reg[3] <= ne;
      if (s == 0) m_reg[0] <= bus_wdata;
      if (s == 1) m_reg[1] <= bus_wdata;
      if (s == 4) m_reg[4] <= bus_wdata;
      if (s == 5) m_reg[5] <= bus_wdata;
      m_pipe <= '{m_pipe[1], to_bits(pin_in)};
    end
  end

  // ---------------- checking ----------------
  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R5 pin_out vs model", pin_out, to_bits(m_reg[2]));
      check("R5 pin_oe vs model", pin_oe, to_bits(m_reg[0]));
      check("R5 pin_od vs model", pin_od, to_bits(m_reg[1]));
      check("R8 irq vs model", {31'h0, irq}, {31'h0, |(m_reg[3] & m_reg[4])});
      check("R1 rdata vs model", bus_rdata, exp_read());
    end
  end

  // ---------------- stimulus ----------------
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wreg(input logic [11:0] a, input logic [31:0] d,
                      input logic word = 1'b1);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_word = word;
    bus_addr = a; bus_wdata = d;
    step();
    bus_sel = 1'b0; bus_wr = 1'b0; bus_word = 1'b0;
  endtask

  task automatic rexp(input string tag, input logic [11:0] a,
                      input logic [31:0] exp, input logic word = 1'b1);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_word = word; bus_addr = a;
    @(negedge clk);
    check(tag, bus_rdata, exp);
    step();
    bus_sel = 1'b0; bus_word = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    step();

    // R10: reset state
    rexp("R10 dir after reset", 12'h000, 32'h0);
    rexp("R10 odr after reset", 12'h004, 32'h0);
    rexp("R10 dat after reset", 12'h008, 32'h0);
    rexp("R10 evt after reset", 12'h00C, 32'h0);
    rexp("R10 msk after reset", 12'h010, 32'h0);
    rexp("R10 ctl after reset", 12'h014, 32'h0);

    // R4/R5: pins 0..3 outputs, data 1010 on them
    wreg(12'h000, 32'hF000_0000);
    wreg(12'h008, 32'hA000_0000);
    @(negedge clk);
    check("R4 pin_out[3:0]", {28'h0, pin_out[3:0]}, 32'h5);
    check("R5 pin_oe[3:0]", {28'h0, pin_oe[3:0]}, 32'hF);
    step();
    wreg(12'h004, 32'h0000_0001);
    @(negedge clk);
    check("R4 pin_od pin 31", pin_od, 32'h8000_0000);
    step();
    rexp("R1 odr readback", 12'h004, 32'h0000_0001);

    // R11: data write leaves input bits to hardware
    wreg(12'h008, 32'hFFFF_FFFF);
    idle(1);
    rexp("R11 data write input bits", 12'h008, 32'hF000_0000);

    // R2: narrow accesses
    wreg(12'h000, 32'h0, 1'b0);
    rexp("R2 narrow write ignored", 12'h000, 32'hF000_0000);
    rexp("R2 narrow read zero", 12'h000, 32'h0, 1'b0);

    // R3: unmapped offset
    wreg(12'h018, 32'hFFFF_FFFF);
    rexp("R3 unmapped read zero", 12'h018, 32'h0);
    rexp("R3 unmapped write no effect", 12'h010, 32'h0);

    // R11: external toggle on an output pin
    pin_in[0] = 1'b1;
    idle(4);
    rexp("R11 output pin data held", 12'h008, 32'hF000_0000);
    rexp("R11 no event on output pin", 12'h00C, 32'h0);

    // R6/R9: pin 8 rises, control 0 -> any change
    pin_in[8] = 1'b1;
    idle(2);
    rexp("R6 not yet captured", 12'h008, 32'hF000_0000);
    rexp("R6 captured after sync", 12'h008, 32'hF080_0000);
    rexp("R9 any-change event", 12'h00C, 32'h0080_0000);
    @(negedge clk);
    check("R8 masked event no irq", {31'h0, irq}, 32'h0);
    step();
    wreg(12'h010, 32'h0080_0000);
    @(negedge clk);
    check("R8 unmasked event irq", {31'h0, irq}, 32'h1);
    step();

    // R7: write-one-to-clear
    wreg(12'h00C, 32'h0000_0000);
    rexp("R7 zero write keeps", 12'h00C, 32'h0080_0000);
    wreg(12'h00C, 32'h0080_0000);
    rexp("R7 one write clears", 12'h00C, 32'h0);
    @(negedge clk);
    check("R8 irq drops after clear", {31'h0, irq}, 32'h0);
    step();

    // R9: pin 9 falling-only
    wreg(12'h014, 32'h0040_0000);
    pin_in[9] = 1'b1;
    idle(4);
    rexp("R9 rise ignored when falling-only", 12'h00C, 32'h0);
    pin_in[9] = 1'b0;
    idle(4);
    rexp("R9 fall sets event", 12'h00C, 32'h0040_0000);
    wreg(12'h00C, 32'hFFFF_FFFF);
    rexp("R7 clear all", 12'h00C, 32'h0);

    // R12: clear and new edge on the same clock edge (pin 10)
    pin_in[10] = 1'b1;
    idle(4);
    rexp("R12 setup event", 12'h00C, 32'h0020_0000);
    pin_in[10] = 1'b0;
    step();
    step();
    bus_sel = 1'b1; bus_wr = 1'b1; bus_word = 1'b1;
    bus_addr = 12'h00C; bus_wdata = 32'h0020_0000;
    step();
    bus_sel = 1'b0; bus_wr = 1'b0; bus_word = 1'b0;
    rexp("R12 edge wins over clear", 12'h00C, 32'h0020_0000);

    idle(3);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule